// File: doc/BRIEF.md
# Random TLB Replacement Index Generator

This block picks which translation entry a random-replacement write should overwrite. The entries below a "wired" boundary are protected. The block only ever names an entry at or above that boundary and below the total entry count. A request strobe starts one draw. When the index is ready, the block presents it together with a one-cycle valid flag.

Inside the block is a 32-bit linear congruential generator. Its upper sixteen bits are reduced modulo the number of selectable entries by a restoring remainder unit. The unit is iterative by default, and a parameter can select a single-cycle variant instead. The wired count is then added back to give the index. The block never hands out the same index twice in a row. If a draw matches the index returned last, the generator steps again and the reduction runs again. When exactly one entry is selectable, the answer is fixed. The block returns it on the next cycle without stepping the generator.

Top module: `tlb_rand_index`

## Requirements
- R1: The selectable count is n = total_i - wired_i. Every index presented with valid_o lies in the range wired_i to total_i - 1 inclusive.
- R2: When n equals 1, an accepted request yields valid_o on the very next cycle with idx_o = total_i - 1. The generator state is not stepped, so the next multi-entry draw is the same as if this request had not happened.
- R3: Each generator step replaces the 32-bit state s with (s * 1103515245 + 12345) mod 2^32. The state is 1 after reset.
- R4: A candidate index is ((s >> 16) mod n) + wired_i, computed from the freshly stepped state s.
- R5: When n is greater than 1, a candidate equal to the previously returned index is discarded, and the generator steps again until a candidate differs. The previous index is 0 after reset.
- R6: Every index presented with valid_o, including the fixed n = 1 answer, becomes the previous index for the next request.
- R7: valid_o is high for exactly one cycle per accepted request. When n is greater than 1, busy_o is high from the cycle after acceptance until the cycle in which valid_o rises, and busy_o is low whenever valid_o is high.
- R8: A request raised while busy_o is high is ignored. It produces no extra valid_o pulse and does not step the generator.
- R9: After reset, valid_o and busy_o are 0 and idx_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request one index; accepted only while idle |
| total_i | input | IDX_W+1 | Number of entries in the table (1 to 2^IDX_W) |
| wired_i | input | IDX_W | Number of protected low entries, less than total_i |
| idx_o | output | IDX_W | Chosen entry index (the last one returned) |
| valid_o | output | 1 | One-cycle strobe marking a fresh idx_o |
| busy_o | output | 1 | A draw is in progress |

## Verification
The assertions assume that wired_i is strictly less than total_i, that total_i does not exceed 2^IDX_W, and that both hold steady from the accepted request until its valid_o pulse. The range check and the single-entry check compare idx_o against the live inputs, so they rely on this. The stimulus sets the configuration one cycle before raising the request and changes it only after valid_o is seen. It sweeps every legal wired count for each table size from 1 to 16, and adds the largest table with both extreme boundaries. Stray requests are injected only while busy_o is high.

// File: rtl/tlbrnd_pkg.sv
package tlbrnd_pkg;

   localparam int unsigned          LCG_W    = 32;
   localparam logic [LCG_W-1:0]     LCG_MUL  = 32'd1103515245;
   localparam logic [LCG_W-1:0]     LCG_INC  = 32'd12345;
   localparam logic [LCG_W-1:0]     LCG_SEED = 32'd1;
   localparam int unsigned          DRAW_LSB = 16;
   localparam int unsigned          DRAW_W   = LCG_W - DRAW_LSB;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_DRAW = 1'b1
   } rsel_st_t;

   function automatic logic [LCG_W-1:0] lcg_step(input logic [LCG_W-1:0] s);
      return s * LCG_MUL + LCG_INC;
   endfunction

endpackage

// File: rtl/rnd_lcg.sv
module rnd_lcg
   import tlbrnd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   output logic [DRAW_W-1:0] draw_o
);

   logic [LCG_W-1:0] seed_q;
   logic [LCG_W-1:0] seed_nxt;

   always_comb seed_nxt = lcg_step(seed_q);

   // the draw offered alongside a step is taken from the state being stepped to
   assign draw_o = seed_nxt[LCG_W-1:DRAW_LSB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seed_q <= LCG_SEED;
      else if (step_i) seed_q <= seed_nxt;
   end

endmodule

// File: rtl/rnd_remdiv.sv
module rnd_remdiv #(
   parameter int unsigned DVD_W = 16,
   parameter int unsigned DVS_W = 7,
   parameter bit          ITER  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DVD_W-1:0] dividend_i,
   input  logic [DVS_W-1:0] divisor_i,
   output logic             done_o,
   output logic [DVS_W-1:0] rem_o
);

   if (DVD_W < DVS_W) begin : g_bad_w
      $error("rnd_remdiv: dividend narrower than divisor");
   end

   if (ITER) begin : g_iter
      localparam int unsigned CNT_W = $clog2(DVD_W + 1);

      logic [DVS_W-1:0] rem_q;
      logic [DVS_W-1:0] dvs_q;
      logic [DVD_W-1:0] dvd_q;
      logic [CNT_W-1:0] cnt_q;
      logic             run_q;
      logic             done_q;
      logic [DVS_W:0]   trial;
      logic [DVS_W+1:0] diff;
      logic [DVS_W-1:0] rem_nxt;

      // one restoring step: bring in the next dividend bit, subtract if it fits
      always_comb begin
         trial = {rem_q, dvd_q[DVD_W-1]};
         diff  = {1'b0, trial} - {2'b00, dvs_q};
         if (diff[DVS_W+1]) rem_nxt = trial[DVS_W-1:0];
         else               rem_nxt = diff[DVS_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q  <= '0;
            dvs_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
         end else if (start_i) begin
            rem_q  <= '0;
            dvs_q  <= divisor_i;
            dvd_q  <= dividend_i;
            cnt_q  <= CNT_W'(DVD_W);
            run_q  <= 1'b1;
            done_q <= 1'b0;
         end else if (run_q) begin
            rem_q  <= rem_nxt;
            dvd_q  <= dvd_q << 1;
            cnt_q  <= cnt_q - 1'b1;
            run_q  <= (cnt_q != CNT_W'(1));
            done_q <= (cnt_q == CNT_W'(1));
         end else begin
            done_q <= 1'b0;
         end
      end

      assign done_o = done_q;
      assign rem_o  = rem_q;
   end else begin : g_flat
      logic [DVS_W-1:0] rem_q;
      logic             done_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q  <= '0;
            done_q <= 1'b0;
         end else begin
            done_q <= start_i;
            if (start_i) rem_q <= DVS_W'(dividend_i % DVD_W'(divisor_i));
         end
      end

      assign done_o = done_q;
      assign rem_o  = rem_q;
   end

endmodule

// File: rtl/tlb_rand_index.sv
module tlb_rand_index
   import tlbrnd_pkg::*;
#(
   parameter int unsigned IDX_W    = 6,
   parameter bit          REM_ITER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [IDX_W:0]   total_i,
   input  logic [IDX_W-1:0] wired_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             valid_o,
   output logic             busy_o
);

   localparam int unsigned CNT_W = IDX_W + 1;

   if (IDX_W < 1 || IDX_W >= DRAW_W) begin : g_bad_idx
      $error("tlb_rand_index: IDX_W must lie between 1 and %0d", DRAW_W - 1);
   end

   rsel_st_t          st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  wired_q;
   logic [IDX_W-1:0]  prev_q;
   logic              valid_q;

   logic [CNT_W-1:0]  cnt_now;
   logic [CNT_W-1:0]  divisor;
   logic              accept;
   logic              single;
   logic              launch;
   logic              redraw;
   logic              finish;
   logic              step;
   logic [DRAW_W-1:0] draw;
   logic              rem_done;
   logic [CNT_W-1:0]  rem;
   logic [CNT_W-1:0]  cand;

   assign cnt_now = total_i - {1'b0, wired_i};
   assign accept  = (st_q == ST_IDLE) && req_i;
   assign single  = accept && (cnt_now == CNT_W'(1));
   assign launch  = accept && !single;
   assign divisor = (st_q == ST_IDLE) ? cnt_now : cnt_q;

   assign cand    = rem + {1'b0, wired_q};
   assign redraw  = (st_q == ST_DRAW) && rem_done && (cand == {1'b0, prev_q});
   assign finish  = (st_q == ST_DRAW) && rem_done && !redraw;
   assign step    = launch || redraw;

   rnd_lcg u_lcg (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .draw_o (draw)
   );

   rnd_remdiv #(
      .DVD_W (DRAW_W),
      .DVS_W (CNT_W),
      .ITER  (REM_ITER)
   ) u_rem (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (step),
      .dividend_i (draw),
      .divisor_i  (divisor),
      .done_o     (rem_done),
      .rem_o      (rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         wired_q <= '0;
         prev_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= single || finish;
         if (launch) begin
            st_q    <= ST_DRAW;
            cnt_q   <= cnt_now;
            wired_q <= wired_i;
         end else if (finish) begin
            st_q    <= ST_IDLE;
         end
         if (single)      prev_q <= IDX_W'(total_i - CNT_W'(1));
         else if (finish) prev_q <= IDX_W'(cand);
      end
   end

   // the held previous index doubles as the output register
   assign idx_o   = prev_q;
   assign valid_o = valid_q;
   assign busy_o  = (st_q == ST_DRAW);

endmodule

// File: rtl/tlb_rand_index_chk.sv
module tlb_rand_index_chk #(
   parameter int unsigned IDX_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_i,
   input logic [IDX_W:0]   total_i,
   input logic [IDX_W-1:0] wired_i,
   input logic [IDX_W-1:0] idx_o,
   input logic             valid_o,
   input logic             busy_o
);

   logic [IDX_W-1:0] last_q;
   logic [IDX_W:0]   sel_n;

   assign sel_n = total_i - {1'b0, wired_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last_q <= '0;
      else if (valid_o) last_q <= idx_o;
   end

   a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (({1'b0, idx_o} < total_i) && (idx_o >= wired_i)));

   a_r2_single_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && req_i && sel_n == (IDX_W+1)'(1))
      |=> (valid_o && (({1'b0, idx_o} + (IDX_W+1)'(1)) == $past(total_i))));

   a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && sel_n > (IDX_W+1)'(1)) |-> (idx_o != last_q));

   a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !busy_o);

   a_r7_done_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> valid_o);

   a_r6_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (idx_o == last_q));

endmodule

bind tlb_rand_index tlb_rand_index_chk #(.IDX_W(IDX_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_i   (req_i),
   .total_i (total_i),
   .wired_i (wired_i),
   .idx_o   (idx_o),
   .valid_o (valid_o),
   .busy_o  (busy_o)
);

// File: tb/tb_tlb_rand_index.sv
`timescale 1ns/1ps
module tb_tlb_rand_index;

   localparam int IDX_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_i = 1'b0;
   logic [IDX_W:0]   total_i = '0;
   logic [IDX_W-1:0] wired_i = '0;
   logic [IDX_W-1:0] idx_o;
   logic             valid_o;
   logic             busy_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit finished = 1'b0;

   logic [31:0]      m_seed = 32'd1;
   logic [IDX_W-1:0] m_prev = '0;

   always #2 clk = ~clk;

   tlb_rand_index #(.IDX_W(IDX_W)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_i),
      .total_i (total_i),
      .wired_i (wired_i),
      .idx_o   (idx_o),
      .valid_o (valid_o),
      .busy_o  (busy_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected index from the requirements: R3 step, R4 reduction, R5 rejection, R2 fixed case
   function automatic int model_next(input int tot, input int wir);
      int n = tot - wir;
      int c;
      if (n == 1) begin
         m_prev = IDX_W'(tot - 1);
         return tot - 1;
      end
      do begin
         m_seed = m_seed * 32'd1103515245 + 32'd12345;
         c = int'(m_seed[31:16]) % n + wir;
      end while (c == int'(m_prev));
      m_prev = IDX_W'(c);
      return c;
   endfunction

   task automatic run_req(input int tot, input int wir, input bit poke);
      int exp;
      int prev_out;
      int waited;
      int extra;
      prev_out = int'(m_prev);
      exp = model_next(tot, wir);
      @(negedge clk);
      total_i = (IDX_W+1)'(tot);
      wired_i = IDX_W'(wir);
      @(negedge clk);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      if (tot - wir == 1) begin
         chk("R2 single-entry valid next cycle", int'(valid_o), 1);
         chk("R2 single-entry index", int'(idx_o), exp);
         chk("R7 no busy for single entry", int'(busy_o), 0);
      end else begin
         chk("R7 busy after accept", int'(busy_o), 1);
         if (poke) begin
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
         end
         waited = 0;
         while (!valid_o && waited < 3000) begin
            @(negedge clk);
            waited++;
         end
         chk("R7 valid arrives", int'(valid_o), 1);
         chk("R7 busy low with valid", int'(busy_o), 0);
         chk("R4 drawn index", int'(idx_o), exp);
         checks++;
         if (int'(idx_o) < wir || int'(idx_o) >= tot) begin
            errors++;
            $display("FAIL R1 range: actual=%0d expected=%0d..%0d", idx_o, wir, tot - 1);
         end
         checks++;
         if (int'(idx_o) == prev_out) begin
            errors++;
            $display("FAIL R5 repeat: actual=%0d expected!=%0d", idx_o, prev_out);
         end
      end
      @(negedge clk);
      chk("R7 valid single pulse", int'(valid_o), 0);
      chk("R6 index held", int'(idx_o), exp);
      if (poke) begin
         extra = 0;
         for (int k = 0; k < 40; k++) begin
            if (valid_o) extra++;
            @(negedge clk);
         end
         chk("R8 request during busy ignored", extra, 0);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL R7 watchdog: actual=%0d expected<=190000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1;
      chk("R9 valid in reset", int'(valid_o), 0);
      chk("R9 busy in reset", int'(busy_o), 0);
      chk("R9 index in reset", int'(idx_o), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 valid after reset", int'(valid_o), 0);
      chk("R9 busy after reset", int'(busy_o), 0);

      // first draw from reset seed: R3 seed 1, R5 previous 0 forces a redraw
      run_req(2, 0, 1'b0);
      chk("R5 reset previous rejected", int'(idx_o), 1);

      for (int t = 1; t <= 16; t++) begin
         for (int w = 0; w < t; w++) begin
            run_req(t, w, 1'b0);
            run_req(t, w, (w % 3) == 1);
         end
      end

      // R2: fixed answer between draws must not disturb the generator
      run_req(10, 2, 1'b0);
      run_req(10, 9, 1'b0);
      run_req(10, 2, 1'b0);

      for (int k = 0; k < 6; k++) run_req(64, 0, k == 2);
      run_req(64, 63, 1'b0);
      run_req(64, 62, 1'b0);
      run_req(64, 62, 1'b1);
      run_req(33, 5, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule